// File: doc/BRIEF.md
# Per-Highway TDM Frame Offset Aligner

This block turns one shared frame sync and one tick clock into independent timing for a set of serial TDM highways, separately for the receive and transmit side of each. The tick clock runs at four times the bit rate of the fastest highway, so one 125 µs frame always spans 4096 ticks. Each highway direction is given a rate (32, 64 or 128 slots per frame) and an offset from the sync in bytes, bits and quarter bits. From these, the block tells the neighbouring deserializer or serializer which slot and bit are current. It also tells it on which tick to sample (receive) or launch (transmit), and when the shifted frame begins.

The offset is counted in quarter bits of the highway's own rate, so one quarter step is 1, 2 or 4 ticks. The range therefore grows with slower rates. New rate and offset values are presented on static inputs and are taken over only on the clock edge that samples the frame sync. A frame in progress is never cut short or re-timed. The internal tick count restarts at each sync and wraps by itself if a sync is missing.

Top module: `tdm_frame_aligner`

## Requirements
- R1: While `rst_n` is low, every strobe and frame-start output is 0 and every slot and bit index reads 0. The outputs stay inert until the first clock edge with `rst_n` high.
- R2: The tick count becomes 0 on the clock edge that samples `fsync` high. On every other edge it advances by one and wraps from 4095 to 0.
- R3: Each offset input is 12 bits per lane: byte count in [11:5], bit count in [4:2], quarter count in [1:0]. The offset in ticks is (byte·32 + bit·4 + quarter)·Q, where Q is the ticks per quarter bit of that lane's rate.
- R4: Rate code 0 gives 32 slots and 16 ticks per bit. Code 1 gives 64 slots and 8 ticks per bit. Codes 2 and 3 give 128 slots and 4 ticks per bit.
- R5: With rel = (tick − offset) mod 4096, the slot index is rel / (8·ticks-per-bit) and the bit index is (rel / ticks-per-bit) mod 8.
- R6: A transmit lane's strobe is high when rel mod ticks-per-bit is 0. A receive lane's strobe is high when that remainder equals half a bit.
- R7: A lane's frame-start output is high exactly when rel is 0, which happens once per 4096 ticks.
- R8: The byte field is taken modulo the lane's slot count, so bytes beyond the frame of a slow rate wrap.
- R9: Rate and offset inputs take effect only on the edge that samples `fsync` high. Changes at any other time do not affect the outputs until then.
- R10: Receive and transmit lanes of the same highway use their own rate and offset and do not influence each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, 4× the fastest bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Shared frame sync, one tick wide |
| rx_rate | input | 2·NUM_HW | Receive rate code per highway |
| tx_rate | input | 2·NUM_HW | Transmit rate code per highway |
| rx_ofs | input | 12·NUM_HW | Receive offset per highway |
| tx_ofs | input | 12·NUM_HW | Transmit offset per highway |
| rx_fstart | output | NUM_HW | Receive shifted frame boundary |
| rx_strobe | output | NUM_HW | Receive mid-bit sample enable |
| rx_slot | output | 7·NUM_HW | Receive slot index |
| rx_bit | output | 3·NUM_HW | Receive bit index |
| tx_fstart | output | NUM_HW | Transmit shifted frame boundary |
| tx_strobe | output | NUM_HW | Transmit launch enable |
| tx_slot | output | 7·NUM_HW | Transmit slot index |
| tx_bit | output | 3·NUM_HW | Transmit bit index |

## Verification
Configuration take-over and a lane's own frame start can land on the same edge. This happens for a lane with zero offset, whose frame begins on the very tick the sync reloads its settings. The bench provokes it by applying fresh settings with zero offsets together with a sync pulse, and by pulsing sync early, in the middle of a frame. Every lane output is then compared each tick against an arithmetic model. The model switches settings at the sync edge only, so a frame start computed from stale settings, or settings taken too early, shows up as a mismatch.

// File: rtl/tdm_align_pkg.sv
package tdm_align_pkg;

    localparam int BIT_LOG2 = 3;
    localparam int QTR_LOG2 = 2;

    typedef enum logic [1:0] {
        RATE_LO     = 2'd0,
        RATE_MID    = 2'd1,
        RATE_HI     = 2'd2,
        RATE_HI_ALT = 2'd3
    } rate_e;

    // Number of halvings of the fastest rate: ticks per quarter bit = 1 << shift.
    function automatic logic [1:0] rate_shift(input logic [1:0] code);
        case (code)
            RATE_LO:  return 2'd2;
            RATE_MID: return 2'd1;
            default:  return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/tdm_align_timebase.sv
module tdm_align_timebase #(
    parameter int TICK_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync,
    output logic [TICK_W-1:0] tick,
    output logic              run
);

    typedef struct packed {
        logic [TICK_W-1:0] cnt;
        logic              run;
    } tb_t;

    tb_t tb_d, tb_q;

    always_comb begin
        tb_d     = tb_q;
        tb_d.run = 1'b1;
        if (fsync) tb_d.cnt = '0;
        else       tb_d.cnt = tb_q.cnt + TICK_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tb_q <= '0;
        else        tb_q <= tb_d;
    end

    assign tick = tb_q.cnt;
    assign run  = tb_q.run;

    assert_sync_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |=> (tick == '0));

    assert_tick_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !fsync |=> (tick == $past(tick) + TICK_W'(1)));

endmodule

// File: rtl/tdm_align_lane.sv
module tdm_align_lane
    import tdm_align_pkg::*;
#(
    parameter int SLOT_LOG2 = 7,
    parameter bit IS_RX     = 1'b0,
    parameter int TICK_W    = SLOT_LOG2 + BIT_LOG2 + QTR_LOG2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fsync,
    input  logic                 run,
    input  logic [TICK_W-1:0]    tick,
    input  logic [1:0]           rate_in,
    input  logic [TICK_W-1:0]    ofs_in,
    output logic                 fstart,
    output logic                 strobe,
    output logic [SLOT_LOG2-1:0] slot,
    output logic [BIT_LOG2-1:0]  bit_idx
);

    localparam int SUB_W = BIT_LOG2 + QTR_LOG2;

    typedef struct packed {
        logic [1:0]        rate;
        logic [TICK_W-1:0] ofs;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    // Settings are reloaded only on the sync edge.
    always_comb begin
        cfg_d = cfg_q;
        if (fsync) begin
            cfg_d.rate = rate_in;
            cfg_d.ofs  = ofs_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    logic [1:0]           sh;
    logic [2:0]           sh_slot, sh_bit, sh_half;
    logic [SLOT_LOG2-1:0] byte_keep;
    logic [TICK_W-1:0]    units, off, rel, ph_mask, half, phase;
    logic                 hit;

    always_comb begin
        sh        = rate_shift(cfg_q.rate);
        byte_keep = cfg_q.ofs[TICK_W-1 -: SLOT_LOG2] & ({SLOT_LOG2{1'b1}} >> sh);
        units     = {byte_keep, cfg_q.ofs[SUB_W-1:0]};
        off       = units << sh;
        rel       = tick - off;
        sh_slot   = 3'(SUB_W) + {1'b0, sh};
        sh_bit    = 3'(QTR_LOG2) + {1'b0, sh};
        sh_half   = 3'(QTR_LOG2 - 1) + {1'b0, sh};
        ph_mask   = (TICK_W'(1) << sh_bit) - TICK_W'(1);
        half      = TICK_W'(1) << sh_half;
        phase     = rel & ph_mask;
    end

    generate
        if (IS_RX) begin : g_rx
            assign hit = (phase == half);
        end else begin : g_tx
            assign hit = (phase == '0);
        end
    endgenerate

    assign slot    = SLOT_LOG2'(rel >> sh_slot);
    assign bit_idx = BIT_LOG2'(rel >> sh_bit);
    assign strobe  = run & hit;
    assign fstart  = run & (rel == '0);

    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !fsync |=> $stable(cfg_q));

    assert_fstart_origin_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fstart |-> (slot == '0 && bit_idx == '0));

    generate
        if (IS_RX) begin : g_chk_rx
            assert_rx_midbit_R6: assert property (@(posedge clk) disable iff (!rst_n)
                strobe |-> !fstart);
        end else begin : g_chk_tx
            assert_tx_launch_R6: assert property (@(posedge clk) disable iff (!rst_n)
                fstart |-> strobe);
        end
    endgenerate

endmodule

// File: rtl/tdm_frame_aligner.sv
module tdm_frame_aligner
    import tdm_align_pkg::*;
#(
    parameter int NUM_HW    = 4,
    parameter int SLOT_LOG2 = 7,
    parameter int TICK_W    = SLOT_LOG2 + BIT_LOG2 + QTR_LOG2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        fsync,
    input  logic [2*NUM_HW-1:0]         rx_rate,
    input  logic [2*NUM_HW-1:0]         tx_rate,
    input  logic [TICK_W*NUM_HW-1:0]    rx_ofs,
    input  logic [TICK_W*NUM_HW-1:0]    tx_ofs,
    output logic [NUM_HW-1:0]           rx_fstart,
    output logic [NUM_HW-1:0]           rx_strobe,
    output logic [SLOT_LOG2*NUM_HW-1:0] rx_slot,
    output logic [BIT_LOG2*NUM_HW-1:0]  rx_bit,
    output logic [NUM_HW-1:0]           tx_fstart,
    output logic [NUM_HW-1:0]           tx_strobe,
    output logic [SLOT_LOG2*NUM_HW-1:0] tx_slot,
    output logic [BIT_LOG2*NUM_HW-1:0]  tx_bit
);

    logic [TICK_W-1:0] tick;
    logic              run;

    tdm_align_timebase #(.TICK_W(TICK_W)) u_timebase (
        .clk   (clk),
        .rst_n (rst_n),
        .fsync (fsync),
        .tick  (tick),
        .run   (run)
    );

    generate
        for (genvar h = 0; h < NUM_HW; h++) begin : g_hw
            tdm_align_lane #(.SLOT_LOG2(SLOT_LOG2), .IS_RX(1'b1), .TICK_W(TICK_W)) u_rx (
                .clk     (clk),
                .rst_n   (rst_n),
                .fsync   (fsync),
                .run     (run),
                .tick    (tick),
                .rate_in (rx_rate[2*h +: 2]),
                .ofs_in  (rx_ofs[TICK_W*h +: TICK_W]),
                .fstart  (rx_fstart[h]),
                .strobe  (rx_strobe[h]),
                .slot    (rx_slot[SLOT_LOG2*h +: SLOT_LOG2]),
                .bit_idx (rx_bit[BIT_LOG2*h +: BIT_LOG2])
            );
            tdm_align_lane #(.SLOT_LOG2(SLOT_LOG2), .IS_RX(1'b0), .TICK_W(TICK_W)) u_tx (
                .clk     (clk),
                .rst_n   (rst_n),
                .fsync   (fsync),
                .run     (run),
                .tick    (tick),
                .rate_in (tx_rate[2*h +: 2]),
                .ofs_in  (tx_ofs[TICK_W*h +: TICK_W]),
                .fstart  (tx_fstart[h]),
                .strobe  (tx_strobe[h]),
                .slot    (tx_slot[SLOT_LOG2*h +: SLOT_LOG2]),
                .bit_idx (tx_bit[BIT_LOG2*h +: BIT_LOG2])
            );
        end
    endgenerate

endmodule

// File: tb/tdm_frame_aligner_tb.sv
module tdm_frame_aligner_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fsync = 1'b0;
    logic [2*N-1:0]  rx_rate, tx_rate;
    logic [12*N-1:0] rx_ofs, tx_ofs;
    logic [N-1:0]    rx_fstart, rx_strobe, tx_fstart, tx_strobe;
    logic [7*N-1:0]  rx_slot, tx_slot;
    logic [3*N-1:0]  rx_bit, tx_bit;

    logic [1:0]  rr [N];
    logic [1:0]  tr [N];
    logic [11:0] ro [N];
    logic [11:0] to [N];

    always_comb begin
        for (int h = 0; h < N; h++) begin
            rx_rate[2*h +: 2]  = rr[h];
            tx_rate[2*h +: 2]  = tr[h];
            rx_ofs[12*h +: 12] = ro[h];
            tx_ofs[12*h +: 12] = to[h];
        end
    end

    tdm_frame_aligner u_dut (
        .clk(clk), .rst_n(rst_n), .fsync(fsync),
        .rx_rate(rx_rate), .tx_rate(tx_rate), .rx_ofs(rx_ofs), .tx_ofs(tx_ofs),
        .rx_fstart(rx_fstart), .rx_strobe(rx_strobe), .rx_slot(rx_slot), .rx_bit(rx_bit),
        .tx_fstart(tx_fstart), .tx_strobe(tx_strobe), .tx_slot(tx_slot), .tx_bit(tx_bit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;

    // Bench model state
    int m_tick = 0;
    bit m_run = 0;
    int m_rr [N];
    int m_tr [N];
    int m_ro [N];
    int m_to [N];

    function automatic logic [11:0] mk(int b, int t, int q);
        return 12'(b * 32 + t * 4 + q);
    endfunction

    // R4: code 0 -> 32 slots, 1 -> 64, 2 and 3 -> 128
    function automatic int ticks_per_bit(int code);
        int slots = (code >= 2) ? 128 : (32 << code);
        return 4096 / (slots * 8);
    endfunction

    // R3 + R8: offset in ticks, byte reduced modulo slot count
    function automatic int rel_of(int code, int ofs, int t);
        int tpb = ticks_per_bit(code);
        int slots = 4096 / (tpb * 8);
        int b = (ofs / 32) % slots;
        int bt = (ofs / 4) % 8;
        int q = ofs % 4;
        int off = (b * 32 + bt * 4 + q) * tpb / 4;
        return (t - off + 4096) % 4096;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_lane(bit is_rx, int h, int code, int ofs);
        int tpb = ticks_per_bit(code);
        int rel = rel_of(code, ofs, m_tick);
        int e_slot = rel / (tpb * 8);
        int e_bit = (rel / tpb) % 8;
        int e_stb = m_run && ((rel % tpb) == (is_rx ? tpb / 2 : 0));
        int e_fs = m_run && (rel == 0);
        int a_slot = is_rx ? int'(rx_slot[7*h +: 7]) : int'(tx_slot[7*h +: 7]);
        int a_bit = is_rx ? int'(rx_bit[3*h +: 3]) : int'(tx_bit[3*h +: 3]);
        int a_stb = is_rx ? int'(rx_strobe[h]) : int'(tx_strobe[h]);
        int a_fs = is_rx ? int'(rx_fstart[h]) : int'(tx_fstart[h]);
        chk(a_slot == e_slot && a_bit == e_bit, "R5", is_rx ? "rx slot*8+bit" : "tx slot*8+bit",
            a_slot * 8 + a_bit, e_slot * 8 + e_bit);
        chk(a_stb == e_stb, "R6", is_rx ? "rx strobe" : "tx strobe", a_stb, e_stb);
        chk(a_fs == e_fs, "R7", is_rx ? "rx fstart" : "tx fstart", a_fs, e_fs);
    endtask

    // Model update (R2, R9) and per-tick comparison of every lane (R10)
    always @(posedge clk) begin
        if (!rst_n) begin
            m_tick = 0;
            m_run = 0;
            for (int h = 0; h < N; h++) begin
                m_rr[h] = 0; m_tr[h] = 0; m_ro[h] = 0; m_to[h] = 0;
            end
        end else begin
            if (fsync) begin
                m_tick = 0;
                for (int h = 0; h < N; h++) begin
                    m_rr[h] = int'(rr[h]); m_tr[h] = int'(tr[h]);
                    m_ro[h] = int'(ro[h]); m_to[h] = int'(to[h]);
                end
            end else begin
                m_tick = (m_tick + 1) % 4096;
            end
            m_run = 1;
        end
        #2;
        if (rst_n) begin
            for (int h = 0; h < N; h++) begin
                check_lane(1'b1, h, m_rr[h], m_ro[h]);
                check_lane(1'b0, h, m_tr[h], m_to[h]);
            end
        end
    end

    task automatic wait_ticks(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_sync();
        @(negedge clk);
        fsync = 1'b1;
        @(negedge clk);
        fsync = 1'b0;
    endtask

    bit done = 0;

    initial begin
        for (int h = 0; h < N; h++) begin
            rr[h] = 2'd0; tr[h] = 2'd0; ro[h] = '0; to[h] = '0;
        end
        // R1: reset state
        repeat (4) begin
            @(negedge clk);
            chk(rx_strobe == '0 && tx_strobe == '0, "R1", "strobes in reset",
                int'({rx_strobe, tx_strobe}), 0);
            chk(rx_fstart == '0 && tx_fstart == '0, "R1", "fstart in reset",
                int'({rx_fstart, tx_fstart}), 0);
            chk(rx_slot == '0 && tx_slot == '0 && rx_bit == '0 && tx_bit == '0, "R1",
                "indices in reset", int'(rx_slot) + int'(tx_slot), 0);
        end
        rst_n = 1'b1;
        wait_ticks(300);

        // Set 1: mixed rates, R3 fields at extremes, R10 rx/tx differ
        rr[0] = 2'd0; rr[1] = 2'd1; rr[2] = 2'd2; rr[3] = 2'd2;
        tr[0] = 2'd2; tr[1] = 2'd1; tr[2] = 2'd0; tr[3] = 2'd1;
        ro[0] = mk(0, 0, 0);  ro[1] = mk(5, 3, 1);  ro[2] = mk(127, 7, 3); ro[3] = mk(64, 0, 2);
        to[0] = mk(1, 2, 3);  to[1] = mk(63, 7, 1); to[2] = mk(31, 0, 0);  to[3] = mk(0, 4, 2);
        pulse_sync();
        // R2: run past the wrap with no sync
        wait_ticks(4096 + 700);

        // Set 2 presented mid-frame: R9 requires no effect until the sync
        // R8: bytes beyond slot count; R4: code 3
        rr[0] = 2'd1; rr[1] = 2'd0; rr[2] = 2'd3; rr[3] = 2'd2;
        tr[0] = 2'd0; tr[1] = 2'd2; tr[2] = 2'd3; tr[3] = 2'd0;
        ro[0] = mk(100, 1, 1); ro[1] = mk(45, 6, 3); ro[2] = mk(3, 3, 3);  ro[3] = mk(0, 0, 0);
        to[0] = mk(127, 7, 3); to[1] = mk(0, 0, 1);  to[2] = mk(10, 5, 2); to[3] = mk(99, 2, 0);
        wait_ticks(1500);
        pulse_sync();
        wait_ticks(4096 * 2);

        // Set 3: zero offsets, frame start coincides with config load; early sync
        for (int h = 0; h < N; h++) begin
            rr[h] = 2'(h % 3); tr[h] = 2'((h + 1) % 3); ro[h] = '0; to[h] = '0;
        end
        pulse_sync();
        wait_ticks(777);
        to[2] = mk(2, 1, 1); ro[1] = mk(17, 2, 2);
        pulse_sync();
        wait_ticks(4096 + 50);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule